// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block loads synthesizer settings over three serial lines: a bit clock, a data line and a load strobe. All three are brought into the system clock domain through a synchronizer chain. Each rising edge of the bit clock shifts one data bit, most significant bit first, into a 19-bit word register. A rising edge of the load strobe copies the word into one of two holding registers. The last bit shifted in acts as a route bit and picks which holding register is written.

The divider register gives an 11-bit main count and a 7-bit swallow count to the feedback divider, which lies outside this block. The reference register holds a 14-bit reference ratio and a prescaler-ratio select bit. The block also contains the reference divider. This divider is clocked by the oscillator, which is the block clock. It produces a one-cycle comparison pulse at the programmed ratio.

Top module: `syn_prog_if`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of a 19-bit word, and the older bits move one place up. The first bit sent ends up in bit 18. When more than 19 bits are sent before a load, only the last 19 are kept.
- R2: A rising edge of `ser_le` writes exactly one holding register. Bit 0 of the word (the last bit sent) selects it: 1 selects the divider register and 0 selects the reference register.
- R3: A load with route bit 1 sets `main_div_o` = word[18:8] and `swallow_o` = word[7:1]. It leaves `ref_div_o` and `pre_sel_o` unchanged.
- R4: A load with route bit 0 sets `ref_div_o` = word[14:1] and `pre_sel_o` = word[15]. On `pre_sel_o`, 0 selects the 64/65 prescaler and 1 selects 128/129. Word bits 18..16 are ignored, and the divider outputs are unchanged.
- R5: The four configuration outputs change only on a load. Shifting bits with `ser_le` held high or held low leaves them unchanged.
- R6: After reset, all configuration outputs are 0.
- R7: When `ref_div_o` holds a value N of 2 or more, `ref_pulse_o` is one cycle wide and repeats every N cycles.
- R8: When `ref_div_o` is 0 or 1, `ref_pulse_o` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator / system clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, rising edge loads |
| main_div_o | output | 11 | Main (programmable) count |
| swallow_o | output | 7 | Swallow count |
| ref_div_o | output | 14 | Reference divide ratio |
| pre_sel_o | output | 1 | Prescaler select (0: 64/65, 1: 128/129) |
| ref_pulse_o | output | 1 | Reference comparison pulse |

## Verification
Four properties are checked on every cycle:
- Each load writes at most one of the two holding registers.
- Configuration outputs hold steady in any cycle with no load.
- At ratios of 2 or more, the reference pulse is never two cycles wide.
- At ratios of 0 and 1, the pulse is continuous.

Only the bench scenarios can show the rest. This covers which bit positions land in which fields, the most-significant-bit-first order, and the keeping of only the last 19 bits. It also covers whether the route bit steers to the correct register and the exact pulse period at a given ratio.

// File: rtl/syn_prog_pkg.sv
package syn_prog_pkg;
    parameter int unsigned SWALLOW_W = 7;
    parameter int unsigned MAIN_W    = 11;
    parameter int unsigned REF_W     = 14;
    parameter int unsigned WORD_W    = 1 + SWALLOW_W + MAIN_W;
    parameter int unsigned REFCFG_W  = REF_W + 1;

    typedef struct packed {
        logic [MAIN_W-1:0]    main_div;
        logic [SWALLOW_W-1:0] swallow;
    } div_cfg_t;

    typedef struct packed {
        logic             pre_sel;
        logic [REF_W-1:0] ref_div;
    } ref_cfg_t;
endpackage

// File: rtl/syn_in_sync.sv
module syn_in_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/syn_cfg_loader.sv
module syn_cfg_loader
    import syn_prog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     shift_en,
    input  logic     data_in,
    input  logic     load_en,
    output div_cfg_t div_cfg_o,
    output ref_cfg_t ref_cfg_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        div_cfg_t          div;
        ref_cfg_t          refc;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            if (st_q.word[0]) st_d.div  = div_cfg_t'(st_q.word[WORD_W-1:1]);
            else              st_d.refc = ref_cfg_t'(st_q.word[REFCFG_W:1]);
        end
        if (shift_en) begin
            st_d.word = {st_q.word[WORD_W-2:0], data_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_cfg_o = st_q.div;
    assign ref_cfg_o = st_q.refc;
endmodule

// File: rtl/syn_ref_div.sv
module syn_ref_div #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = (ratio_i < CNT_W'(2)) ? '0 : ratio_i - CNT_W'(1);
        st_d   = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt   = reload;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt - CNT_W'(1);
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/syn_prog_if.sv
module syn_prog_if
    import syn_prog_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_le,
    output logic [MAIN_W-1:0]    main_div_o,
    output logic [SWALLOW_W-1:0] swallow_o,
    output logic [REF_W-1:0]     ref_div_o,
    output logic                 pre_sel_o,
    output logic                 ref_pulse_o
);
    localparam int unsigned IN_W = 3;

    typedef struct packed {
        logic sclk;
        logic le;
    } edge_st_t;

    logic [IN_W-1:0] raw_in, lvl;
    edge_st_t        edge_d, edge_q;
    logic            shift_en, load_en;
    div_cfg_t        div_cfg;
    ref_cfg_t        ref_cfg;

    assign raw_in = {ser_le, ser_clk, ser_data};

    syn_in_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_in),
        .q_o  (lvl)
    );

    always_comb begin
        edge_d.sclk = lvl[1];
        edge_d.le   = lvl[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign shift_en = lvl[1] & ~edge_q.sclk;
    assign load_en  = lvl[2] & ~edge_q.le;

    syn_cfg_loader u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .data_in  (lvl[0]),
        .load_en  (load_en),
        .div_cfg_o(div_cfg),
        .ref_cfg_o(ref_cfg)
    );

    syn_ref_div #(.CNT_W(REF_W)) u_refdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .ratio_i(ref_cfg.ref_div),
        .pulse_o(ref_pulse_o)
    );

    assign main_div_o = div_cfg.main_div;
    assign swallow_o  = div_cfg.swallow;
    assign ref_div_o  = ref_cfg.ref_div;
    assign pre_sel_o  = ref_cfg.pre_sel;
endmodule

// File: rtl/syn_prog_if_chk.sv
module syn_prog_if_chk
    import syn_prog_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_en,
    input logic [MAIN_W-1:0]    main_div,
    input logic [SWALLOW_W-1:0] swallow,
    input logic [REF_W-1:0]     ref_div,
    input logic                 pre_sel,
    input logic                 ref_pulse
);
    // R2: a load touches at most one holding register
    p_one_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> ($stable(main_div) && $stable(swallow)) || ($stable(ref_div) && $stable(pre_sel)));

    // R5: no load, no change
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(main_div) && $stable(swallow) && $stable(ref_div) && $stable(pre_sel)));

    // R7: single-cycle pulse for ratios of two or more
    p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && ref_div > REF_W'(1) && $stable(ref_div)) |=> !ref_pulse);

    // R8: continuous pulse for ratios 0 and 1
    p_div1_every_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && ref_div < REF_W'(2) && $stable(ref_div)) |=> ref_pulse);
endmodule

bind syn_prog_if syn_prog_if_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .main_div (main_div_o),
    .swallow  (swallow_o),
    .ref_div  (ref_div_o),
    .pre_sel  (pre_sel_o),
    .ref_pulse(ref_pulse_o)
);

// File: tb/syn_prog_if_tb.sv
module syn_prog_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_le = 1'b0;
    logic [10:0] main_div_o;
    logic [6:0]  swallow_o;
    logic [13:0] ref_div_o;
    logic        pre_sel_o;
    logic        ref_pulse_o;

    always #10 clk = ~clk;

    syn_prog_if u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .main_div_o(main_div_o), .swallow_o(swallow_o),
        .ref_div_o(ref_div_o), .pre_sel_o(pre_sel_o), .ref_pulse_o(ref_pulse_o)
    );

    typedef struct {
        logic [10:0] main_div;
        logic [6:0]  swallow;
        logic [13:0] ref_div;
        logic        pre_sel;
        string       tag;
        int          due;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    logic done = 1'b0;
    logic [10:0] m_main = '0;
    logic [6:0]  m_sw = '0;
    logic [13:0] m_ref = '0;
    logic        m_pre = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    // monitor: compares outputs against queued expectations when due
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0 && cyc >= q[0].due) begin
                chk({q[0].tag, " main"},    int'(main_div_o), int'(q[0].main_div));
                chk({q[0].tag, " swallow"}, int'(swallow_o),  int'(q[0].swallow));
                chk({q[0].tag, " ref"},     int'(ref_div_o),  int'(q[0].ref_div));
                chk({q[0].tag, " pre"},     int'(pre_sel_o),  int'(q[0].pre_sel));
                void'(q.pop_front());
            end
        end
    end

    task automatic push_exp(input string tag);
        exp_t e;
        e.main_div = m_main; e.swallow = m_sw;
        e.ref_div = m_ref;   e.pre_sel = m_pre;
        e.tag = tag;         e.due = cyc + 10;
        q.push_back(e);
        repeat (14) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ser_data = b;
        repeat (4) @(negedge clk); ser_clk = 1'b1;
        repeat (4) @(negedge clk); ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        repeat (4) @(negedge clk); ser_le = 1'b1;
        repeat (4) @(negedge clk); ser_le = 1'b0;
    endtask

    task automatic load_div(input logic [10:0] m, input logic [6:0] s, input string tag);
        send_word({m, s, 1'b1});
        pulse_le();
        m_main = m; m_sw = s;
        push_exp(tag);
    endtask

    task automatic load_ref(input logic [2:0] junk, input logic p, input logic [13:0] r,
                            input string tag);
        send_word({junk, p, r, 1'b0});
        pulse_le();
        m_ref = r; m_pre = p;
        push_exp(tag);
    endtask

    task automatic check_period(input int n, input string tag);
        int cnt;
        @(negedge clk);
        while (!ref_pulse_o) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
            end while (!ref_pulse_o);
            chk(tag, cnt, n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6 main reset", int'(main_div_o), 0);
        chk("R6 swallow reset", int'(swallow_o), 0);
        chk("R6 ref reset", int'(ref_div_o), 0);
        chk("R6 pre reset", int'(pre_sel_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8: ratio 0 gives a pulse on every cycle
        check_period(1, "R8 ratio0");

        // R3 / R2: route bit 1 to the divider register
        load_div(11'h5A3, 7'h2C, "R3 R2 div load");
        // R4 / R2: route bit 0 to the reference register, top bits ignored
        load_ref(3'b101, 1'b1, 14'h1ABC, "R4 R2 ref load");
        load_div(11'h7FF, 7'h00, "R3 div extremes");
        load_ref(3'b111, 1'b0, 14'h0005, "R4 ref load pre0");

        // R7: ratio 5
        check_period(5, "R7 ratio5");

        // R1: 6 leading junk bits, only the last 19 count
        for (int i = 0; i < 6; i++) send_bit(i[0]);
        load_div(11'h123, 7'h55, "R1 overlong word");

        // R5: shifting with the strobe high and low changes nothing
        pulse_le();
        push_exp("R5 reload same word");
        @(negedge clk); ser_le = 1'b1;
        send_word({11'h0AA, 7'h11, 1'b1});
        @(negedge clk); ser_le = 1'b0;
        push_exp("R5 shift with le high");
        send_word({3'b000, 1'b1, 14'h0777, 1'b0});
        push_exp("R5 shift with le low");

        // R8: ratio 1
        load_ref(3'b000, 1'b0, 14'h0001, "R4 ref ratio1");
        check_period(1, "R8 ratio1");
        // R7: ratio 2 and a larger ratio
        load_ref(3'b010, 1'b1, 14'h0002, "R4 ref ratio2");
        check_period(2, "R7 ratio2");
        load_ref(3'b000, 1'b0, 14'd300, "R4 ref ratio300");
        check_period(300, "R7 ratio300");

        repeat (20) @(negedge clk);
        chk("R3 queue drained", q.size(), 0);
        finish_run();
    end
endmodule